// File: doc/BRIEF.md
# Comparator Timer Channel (One-Shot and Periodic)

This block is a single channel of a multi-channel event timer. A shared free-running tick counter is fed in on `tick_count`; the channel holds a comparator and raises a one-cycle `expiry_pulse` toward the interrupt logic when the count reaches it. The pulse is qualified by the channel's own enable bit and by the block-wide `glb_en` input. Comparisons are wrap-safe: the event is due once the difference comparator minus count, read as a signed number, is zero or negative. The difference is 32 bits wide in narrow mode and 64 bits wide otherwise.

In one-shot mode the channel fires once and then disarms. In periodic mode a hidden period register is loaded through the comparator words. After each expiry the comparator is stepped forward by the period until it lies after the current count, and only one pulse is produced however many steps are needed. A one-time set-value bit lets software load the comparator itself while in periodic mode. In narrow one-shot mode the channel also fires when the low 32 bits of the count roll over before the match. It records that roll-over in a readable flag.

The register port carries no stream data. It is a plain strobe with a combinational read: every write is accepted in the cycle it is presented, and there is no back-pressure. Interrupt routing, status latching and the counter itself belong to neighbouring blocks.

Top module: `evt_chan_timer`

## Requirements
- R1: After reset, config reads 0x30, both comparator words read 0xFFFFFFFF, word 3 reads 0, the hidden period is zero and no pulse occurs.
- R2: Word select 0 is config, 1 is comparator bits 31:0, 2 is comparator bits 63:32, and 3 reads zero. Config bits are: 0 channel enable, 1 periodic, 2 set-value, 3 narrow (32-bit) mode, 4 periodic-capable (read-only 1), 5 wide-capable (read-only 1), and 6 roll-over flag (read-only).
- R3: An armed, enabled channel is due when comparator minus count is zero or negative as a signed value. This uses the low 32 bits in narrow mode and all 64 bits otherwise.
- R4: In one-shot mode a due channel gives exactly one single-cycle pulse and then disarms.
- R5: In periodic mode with a nonzero period, an expiry gives one pulse and steps the comparator by the period, once per cycle, until it lies after the count. The sum is truncated to 32 bits in narrow mode.
- R6: A comparator word write updates that word only in one-shot mode or when set-value is 1. In periodic mode the same write always updates the matching period word.
- R7: Set-value reads 0 after any write to either comparator word.
- R8: Period writes clear bit 31 in narrow mode and bit 63 in wide mode.
- R9: Writing config with narrow mode set clears comparator and period bits 63:32. Narrow-mode writes to word 2 store zero.
- R10: When narrow one-shot mode is armed and the low count word will roll over before the match, the roll-over gives a pulse and sets flag bit 6. The match then still gives its own pulse.
- R11: The channel arms 1 cycle after a write that sets the enable bit while `glb_en` is 1, or after any comparator write while `glb_en` is 1. It also arms when `glb_en` rises while enabled and the comparator is not all ones. Arming clears the roll-over flag.
- R12: Clearing the enable bit cancels a pending expiry. No pulse is produced while the enable bit or `glb_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Write strobe for the selected word |
| reg_addr | input | 2 | Word select |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected word (combinational) |
| tick_count | input | 64 | Main tick count from the shared counter |
| glb_en | input | 1 | Block-wide enable |
| expiry_pulse | output | 1 | One-cycle expiry event |

## Verification
A table of static comparator/count pairs is tried in both widths. These pairs separate a true signed wrap-safe compare from an unsigned compare. They also separate a 32-bit compare from a 64-bit compare, including a count whose upper word differs while its low word matches. Periodic runs hold the count at the match and then jump it several periods ahead. Exactly one pulse and the final comparator value distinguish correct catch-up from repeated firing or a single step. Narrow one-shot runs carry the count across the 32-bit roll-over. Directed sequences toggle the enable bit, `glb_en`, set-value and narrow mode, so that period masking, truncation, cancellation and re-arming are each seen through readback or through the pulse count.

// File: rtl/evt_tmr_pkg.sv
package evt_tmr_pkg;

  localparam int CFG_EN_B   = 0;
  localparam int CFG_PER_B  = 1;
  localparam int CFG_SETV_B = 2;
  localparam int CFG_M32_B  = 3;
  localparam int CFG_PCAP_B = 4;
  localparam int CFG_WCAP_B = 5;
  localparam int CFG_WRAP_B = 6;
  localparam int CFG_USED   = 7;

  typedef enum logic [1:0] {
    SEL_CFG    = 2'd0,
    SEL_CMP_LO = 2'd1,
    SEL_CMP_HI = 2'd2,
    SEL_NONE   = 2'd3
  } word_sel_e;

  typedef struct packed {
    logic mode32;
    logic set_val;
    logic periodic;
    logic en;
  } chan_cfg_t;

endpackage

// File: rtl/evt_tmr_cmp.sv
module evt_tmr_cmp #(
  parameter int DW = 32,
  localparam int CW = 2 * DW
) (
  input  logic [CW-1:0] cmp,
  input  logic [CW-1:0] cnt,
  input  logic          mode32,
  output logic          due,
  output logic [DW-1:0] lo_gap
);
  logic [CW-1:0] d_wide;
  logic [DW-1:0] d_narrow;

  always_comb begin
    d_wide   = cmp - cnt;
    d_narrow = cmp[DW-1:0] - cnt[DW-1:0];
    lo_gap   = d_narrow;
    // not positive: negative sign bit or exactly zero
    if (mode32) due = d_narrow[DW-1] | (d_narrow == '0);
    else        due = d_wide[CW-1]   | (d_wide == '0);
  end
endmodule

// File: rtl/evt_tmr_regs.sv
module evt_tmr_regs
  import evt_tmr_pkg::*;
#(
  parameter int DW = 32,
  localparam int CW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  input  logic          glb_en,
  input  logic          adv_en,
  input  logic [CW-1:0] adv_cmp,
  output chan_cfg_t     cfg_q,
  output logic [CW-1:0] cmp_q,
  output logic [CW-1:0] period_q,
  output logic          arm_q
);
  chan_cfg_t     cfg_d;
  logic [CW-1:0] cmp_d;
  logic [CW-1:0] per_d;
  logic          arm_d;
  logic          cmp_open;
  logic [DW-1:0] per_word;

  assign cmp_open = ~cfg_q.periodic | cfg_q.set_val;

  always_comb begin
    cfg_d    = cfg_q;
    cmp_d    = cmp_q;
    per_d    = period_q;
    arm_d    = 1'b0;
    per_word = {1'b0, wdata[DW-2:0]};
    if (adv_en) cmp_d = adv_cmp;
    if (wr_en) begin
      unique case (word_sel_e'(addr))
        SEL_CFG: begin
          cfg_d.en       = wdata[CFG_EN_B];
          cfg_d.periodic = wdata[CFG_PER_B];
          cfg_d.set_val  = wdata[CFG_SETV_B];
          cfg_d.mode32   = wdata[CFG_M32_B];
          if (wdata[CFG_M32_B]) begin
            cmp_d[CW-1:DW] = '0;
            per_d[CW-1:DW] = '0;
          end
          if (wdata[CFG_EN_B] && !cfg_q.en && glb_en) arm_d = 1'b1;
        end
        SEL_CMP_LO: begin
          if (cmp_open) cmp_d[DW-1:0] = wdata;
          if (cfg_q.periodic)
            per_d[DW-1:0] = cfg_q.mode32 ? per_word : wdata;
          cfg_d.set_val = 1'b0;
          arm_d         = glb_en;
        end
        SEL_CMP_HI: begin
          if (cmp_open) cmp_d[CW-1:DW] = cfg_q.mode32 ? '0 : wdata;
          if (cfg_q.periodic)
            per_d[CW-1:DW] = cfg_q.mode32 ? '0 : per_word;
          cfg_d.set_val = 1'b0;
          arm_d         = glb_en;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      cmp_q    <= '1;
      period_q <= '0;
      arm_q    <= 1'b0;
    end else begin
      cfg_q    <= cfg_d;
      cmp_q    <= cmp_d;
      period_q <= per_d;
      arm_q    <= arm_d;
    end
  end
endmodule

// File: rtl/evt_tmr_seq.sv
module evt_tmr_seq #(
  parameter int DW = 32,
  localparam int CW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm_req,
  input  logic          chan_en,
  input  logic          glb_en,
  input  logic          mode32,
  input  logic          periodic,
  input  logic [CW-1:0] cmp_q,
  input  logic [CW-1:0] period_q,
  input  logic [CW-1:0] cnt,
  input  logic [DW-1:0] lo_gap,
  input  logic          due_now,
  input  logic          due_next,
  output logic          adv_en,
  output logic          armed,
  output logic          wrap_flag,
  output logic          pulse
);
  logic          glb_q, wrap_pend, catchup;
  logic [DW-1:0] prev_lo;
  logic          go, arm_glb, do_arm, wrapped, rep;
  logic          fire_wrap, fire_match, pend_calc;
  logic [DW-1:0] gap_cl, roll_gap;

  always_comb begin
    go       = chan_en & glb_en;
    arm_glb  = glb_en & ~glb_q & chan_en & (cmp_q != '1);
    do_arm   = go & (arm_req | arm_glb);
    wrapped  = cnt[DW-1:0] < prev_lo;
    rep      = periodic & (period_q != '0);
    fire_wrap  = go & ~do_arm & armed & ~catchup & wrap_pend & wrapped;
    fire_match = go & ~do_arm & armed & ~catchup & ~fire_wrap & due_now;
    adv_en   = go & ~do_arm & armed & due_now & rep & (catchup | fire_match);
    // distance to the match, at least one tick, against distance to roll-over
    gap_cl   = (!lo_gap[DW-1] && lo_gap != '0) ? lo_gap : {{(DW-1){1'b0}}, 1'b1};
    roll_gap = ~cnt[DW-1:0];
    pend_calc = mode32 & ~periodic & (roll_gap < gap_cl);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glb_q     <= 1'b0;
      prev_lo   <= '0;
      pulse     <= 1'b0;
      armed     <= 1'b0;
      wrap_pend <= 1'b0;
      wrap_flag <= 1'b0;
      catchup   <= 1'b0;
    end else begin
      glb_q   <= glb_en;
      prev_lo <= cnt[DW-1:0];
      pulse   <= fire_wrap | fire_match;
      if (!go) begin
        armed     <= 1'b0;
        wrap_pend <= 1'b0;
        catchup   <= 1'b0;
      end else if (do_arm) begin
        armed     <= 1'b1;
        wrap_flag <= 1'b0;
        wrap_pend <= pend_calc;
        catchup   <= 1'b0;
      end else if (armed) begin
        if (catchup) begin
          catchup <= due_now & due_next;
        end else if (fire_wrap) begin
          wrap_pend <= 1'b0;
          wrap_flag <= 1'b1;
        end else if (fire_match) begin
          if (rep) begin
            catchup <= due_next;
          end else begin
            armed     <= 1'b0;
            wrap_pend <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/evt_chan_timer.sv
module evt_chan_timer
  import evt_tmr_pkg::*;
#(
  parameter int DW = 32,
  localparam int CW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr_en,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic [CW-1:0] tick_count,
  input  logic          glb_en,
  output logic          expiry_pulse
);
  chan_cfg_t     cfg_q;
  logic [CW-1:0] cmp_q, period_q, adv_cmp, step_sum;
  logic          arm_q, adv_en, due_now, due_next, armed, wrap_flag;
  logic [DW-1:0] lo_gap, lo_gap_next;
  logic          cfg_en, cfg_m32, cfg_setv;

  assign cfg_en   = cfg_q.en;
  assign cfg_m32  = cfg_q.mode32;
  assign cfg_setv = cfg_q.set_val;
  assign step_sum = cmp_q + period_q;
  assign adv_cmp  = cfg_q.mode32 ? {{DW{1'b0}}, step_sum[DW-1:0]} : step_sum;

  evt_tmr_regs #(.DW(DW)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
    .wdata(reg_wdata), .glb_en(glb_en), .adv_en(adv_en), .adv_cmp(adv_cmp),
    .cfg_q(cfg_q), .cmp_q(cmp_q), .period_q(period_q), .arm_q(arm_q)
  );

  evt_tmr_cmp #(.DW(DW)) cmp_now_i (
    .cmp(cmp_q), .cnt(tick_count), .mode32(cfg_q.mode32),
    .due(due_now), .lo_gap(lo_gap)
  );

  evt_tmr_cmp #(.DW(DW)) cmp_next_i (
    .cmp(adv_cmp), .cnt(tick_count), .mode32(cfg_q.mode32),
    .due(due_next), .lo_gap(lo_gap_next)
  );

  evt_tmr_seq #(.DW(DW)) seq_i (
    .clk(clk), .rst_n(rst_n), .arm_req(arm_q), .chan_en(cfg_q.en),
    .glb_en(glb_en), .mode32(cfg_q.mode32), .periodic(cfg_q.periodic),
    .cmp_q(cmp_q), .period_q(period_q), .cnt(tick_count), .lo_gap(lo_gap),
    .due_now(due_now), .due_next(due_next), .adv_en(adv_en), .armed(armed),
    .wrap_flag(wrap_flag), .pulse(expiry_pulse)
  );

  always_comb begin
    reg_rdata = '0;
    unique case (word_sel_e'(reg_addr))
      SEL_CFG: reg_rdata = {{(DW-CFG_USED){1'b0}}, wrap_flag, 1'b1, 1'b1,
                            cfg_q.mode32, cfg_q.set_val, cfg_q.periodic, cfg_q.en};
      SEL_CMP_LO: reg_rdata = cmp_q[DW-1:0];
      SEL_CMP_HI: reg_rdata = cmp_q[CW-1:DW];
      default:    reg_rdata = '0;
    endcase
  end

  logic unused_ok;
  assign unused_ok = ^lo_gap_next;
endmodule

// File: rtl/evt_tmr_chk.sv
module evt_tmr_chk #(
  parameter int DW = 32,
  localparam int CW = 2 * DW
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [1:0]    addr,
  input logic          glb_en,
  input logic          expiry_pulse,
  input logic          chan_en,
  input logic          mode32,
  input logic          set_val,
  input logic          armed,
  input logic          wrap_flag,
  input logic [CW-1:0] cmp_q,
  input logic [CW-1:0] period_q
);
  // R12
  pulse_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expiry_pulse |-> ($past(chan_en) && $past(glb_en)));

  // R12
  cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |=> !armed);

  // R7
  setval_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr == 2'd1 || addr == 2'd2)) |=> !set_val);

  // R9
  narrow_trunc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode32 |-> (cmp_q[CW-1:DW] == '0 && period_q[CW-1:DW] == '0));

  // R8
  period_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode32 |-> !period_q[CW-1]);

  // R10
  roll_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wrap_flag) |-> expiry_pulse);
endmodule

bind evt_chan_timer evt_tmr_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
  .glb_en(glb_en), .expiry_pulse(expiry_pulse), .chan_en(cfg_en),
  .mode32(cfg_m32), .set_val(cfg_setv), .armed(armed),
  .wrap_flag(wrap_flag), .cmp_q(cmp_q), .period_q(period_q)
);

// File: tb/evt_chan_timer_tb_top.sv
module evt_chan_timer_tb_top;
  localparam logic [31:0] EN = 32'h1, PER = 32'h2, SETV = 32'h4, M32 = 32'h8;

  typedef struct packed {
    logic        m32;
    logic [63:0] cmp;
    logic [63:0] cnt;
    logic        exp;
  } vec_t;

  // R3: static due decisions, narrow and wide
  localparam vec_t VEC [8] = '{
    '{1'b0, 64'd100,              64'd50,               1'b0},
    '{1'b0, 64'd100,              64'd100,              1'b1},
    '{1'b0, 64'd100,              64'd150,              1'b1},
    '{1'b0, 64'h1_0000_0000,      64'h0_FFFF_FFFF,      1'b0},
    '{1'b1, 64'h10,               64'h0_FFFF_FFF0,      1'b0},
    '{1'b1, 64'hFFFF_FFF0,        64'h10,               1'b1},
    '{1'b0, 64'hFFFF_FFF0,        64'h10,               1'b0},
    '{1'b1, 64'h5,                64'h7_0000_0005,      1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [63:0] tick_count = '0;
  logic        glb_en = 1'b0;
  logic        expiry_pulse;

  int checks = 0, fails = 0, pulses = 0, base = 0;
  logic [31:0] rv;
  bit done = 1'b0;

  always #10 clk = ~clk;

  evt_chan_timer dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick_count(tick_count),
    .glb_en(glb_en), .expiry_pulse(expiry_pulse)
  );

  always @(negedge clk) if (rst_n && expiry_pulse) pulses++;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wrap_up;
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    wrap_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    wait_cyc(4);
    // R1 / R2 reset state and map
    rd(2'd0, rv); chk("R1 cfg reset", rv, 32'h30);
    rd(2'd1, rv); chk("R1 cmp lo reset", rv, 32'hFFFF_FFFF);
    rd(2'd2, rv); chk("R1 cmp hi reset", rv, 32'hFFFF_FFFF);
    rd(2'd3, rv); chk("R2 word 3", rv, 32'h0);
    chk("R1 no pulse", pulses, 0);

    glb_en = 1'b1;
    // R3 / R4 table walk
    foreach (VEC[i]) begin
      wr(2'd0, VEC[i].m32 ? M32 : 32'h0);
      tick_count = VEC[i].cnt;
      wr(2'd2, VEC[i].cmp[63:32]);
      wr(2'd1, VEC[i].cmp[31:0]);
      base = pulses;
      wr(2'd0, (VEC[i].m32 ? M32 : 32'h0) | EN);
      wait_cyc(5);
      chk($sformatf("R3 R4 vector %0d", i), pulses - base, {63'd0, VEC[i].exp});
    end

    // R6 R7 R5 periodic, set-value, catch-up
    wr(2'd0, 32'h0); tick_count = 64'd0;
    wr(2'd0, PER | SETV); wr(2'd2, 32'h0);
    wr(2'd0, PER | SETV); wr(2'd1, 32'd100);
    rd(2'd0, rv); chk("R7 set-value cleared", rv, 32'h32);
    wr(2'd1, 32'd10);
    rd(2'd1, rv); chk("R6 cmp kept in periodic", rv, 32'd100);
    base = pulses;
    wr(2'd0, PER | EN);
    wait_cyc(3); chk("R5 not due yet", pulses - base, 0);
    tick_count = 64'd100; wait_cyc(4);
    chk("R5 first expiry", pulses - base, 1);
    rd(2'd1, rv); chk("R5 step by period", rv, 32'd110);
    tick_count = 64'd135; wait_cyc(6);
    chk("R5 one pulse on catch-up", pulses - base, 2);
    rd(2'd1, rv); chk("R5 catch-up cmp", rv, 32'd140);
    tick_count = 64'd140; wait_cyc(4);
    chk("R5 next expiry", pulses - base, 3);

    // R8 narrow period mask
    wr(2'd0, 32'h0); tick_count = 64'd0;
    wr(2'd0, M32 | PER | SETV); wr(2'd1, 32'd20);
    wr(2'd1, 32'h8000_0005);
    wr(2'd0, M32 | PER | EN);
    wait_cyc(3); tick_count = 64'd20; wait_cyc(4);
    rd(2'd1, rv); chk("R8 narrow period bit31 cleared", rv, 32'd25);

    // R8 wide period mask
    wr(2'd0, 32'h0); tick_count = 64'd0;
    wr(2'd0, PER | SETV); wr(2'd2, 32'h0);
    wr(2'd0, PER | SETV); wr(2'd1, 32'd50);
    wr(2'd1, 32'd3); wr(2'd2, 32'h8000_0000);
    wr(2'd0, PER | EN);
    wait_cyc(3); tick_count = 64'd50; wait_cyc(4);
    rd(2'd1, rv); chk("R8 wide step lo", rv, 32'd53);
    rd(2'd2, rv); chk("R8 wide period bit63 cleared", rv, 32'd0);

    // R9 truncation
    wr(2'd0, 32'h0);
    wr(2'd2, 32'h1234); wr(2'd1, 32'h99);
    rd(2'd2, rv); chk("R9 wide hi stored", rv, 32'h1234);
    wr(2'd0, M32);
    rd(2'd2, rv); chk("R9 hi truncated", rv, 32'h0);
    rd(2'd1, rv); chk("R9 lo kept", rv, 32'h99);

    // R10 R11 roll-over in narrow one-shot
    tick_count = 64'h0_FFFF_FFF0;
    wr(2'd1, 32'h10);
    base = pulses;
    wr(2'd0, M32 | EN);
    wait_cyc(3);
    chk("R10 no early pulse", pulses - base, 0);
    rd(2'd0, rv); chk("R10 flag clear", rv, 32'h39);
    tick_count = 64'h1_0000_0000; wait_cyc(3);
    chk("R10 roll-over pulse", pulses - base, 1);
    rd(2'd0, rv); chk("R10 flag set", rv, 32'h79);
    tick_count = 64'h1_0000_0010; wait_cyc(3);
    chk("R10 match after roll-over", pulses - base, 2);
    wait_cyc(3);
    chk("R4 one-shot disarmed", pulses - base, 2);
    wr(2'd1, 32'h20); wait_cyc(2);
    rd(2'd0, rv); chk("R11 re-arm clears flag", rv, 32'h39);

    // R12 cancel and gating, R11 global rise
    wr(2'd0, 32'h0); tick_count = 64'd0;
    wr(2'd2, 32'h0); wr(2'd1, 32'd500);
    base = pulses;
    wr(2'd0, EN); wr(2'd0, 32'h0);
    tick_count = 64'd600; wait_cyc(4);
    chk("R12 disable cancels", pulses - base, 0);
    glb_en = 1'b0;
    wr(2'd0, EN); wait_cyc(4);
    chk("R12 global low suppresses", pulses - base, 0);
    glb_en = 1'b1; wait_cyc(4);
    chk("R11 global rise arms", pulses - base, 1);

    wrap_up();
  end
endmodule